// File: doc/BRIEF.md
# Master Clock Ratio Auto-Detector

This block measures how many master-clock cycles fit into one period of the audio frame clock. It classifies that count as one of six supported oversampling ratios: 128, 192, 256, 384, 512 or 768 master clocks per frame. The result drives the digital filter and serial-interface logic, which need to know the ratio in order to pace their work.

The frame clock arrives asynchronously. It is brought into the master-clock domain through a two-stage synchronizer, and a period is counted between successive rising edges of the synchronized signal. A measured period is accepted for a ratio when it lies within a fixed window of ±`TOL` clocks around that ratio. A count that fits no window selects the largest ratio. The selection only moves after two consecutive measurements agree, so one odd frame cannot disturb it. A lock flag reports that two consecutive measurements both fell inside the window of the same ratio.

Detection runs only when the block is a clock slave. When the block is the clock master, the ratio comes straight from a configuration input and the detector is held cleared.

Top module: `fsratio_detect`

## Requirements
- R1: While `rst` is high at a rising `clk` edge (synchronous, active high), the outputs become `ratio_code` = 5, `ratio_onehot` = 6'b100000 and `locked` = 0.
- R2: `ratio_code` encodes the ratio as 0=128, 1=192, 2=256, 3=384, 4=512, 5=768. `ratio_onehot` bit i is high exactly when `ratio_code` equals i. A steady frame period equal to any supported ratio yields that code with `locked` high.
- R3: A measured period P matches ratio N when N-32 ≤ P ≤ N+32 (`TOL` = 32, inclusive). Where two windows share a value (160 and 224), the smaller ratio wins: 160 gives code 0 and 224 gives code 1. Windows are also inclusive at the outer bounds: 96 gives code 0 and 800 gives code 5.
- R4: Periods that vary from frame to frame but stay inside one ratio's window, such as alternating 250 and 262, keep the selection and `locked` unchanged.
- R5: `locked` rises only after two consecutive measurements both match the same ratio inside its window. It falls after a measurement that differs in class from the one before it, or that matches no window.
- R6: A period that matches no window, for example 64, 300, 650 or 801, is classified as code 5 (768) without a match, so `locked` stays low.
- R7: The selection changes only when two consecutive measurements give the same new class. A single deviating frame between steady frames leaves `ratio_code` unchanged.
- R8: The period counter saturates at 2^`CNT_W`-1 (1023) and never wraps. Reaching saturation while the frame clock is stopped counts as one non-matching measurement. The first edge after the stop measures as saturated and also matches nothing.
- R9: With `slave_mode` low, `ratio_code` follows `cfg_ratio` one clock later (values 6 and 7 map to 5), `locked` is high, and `frame_clk` has no effect.
- R10: A measurement ends at a rising edge of `frame_clk`. If the new level is first present at rising `clk` edge n, the outputs reflect that measurement from edge n+4 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all state is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | High: detect the ratio from `frame_clk`; low: use `cfg_ratio` |
| cfg_ratio | input | 3 | Ratio code used when `slave_mode` is low |
| frame_clk | input | 1 | Asynchronous frame (sample-rate) clock |
| ratio_code | output | 3 | Selected ratio, encoded 0..5 |
| ratio_onehot | output | 6 | One-hot form of `ratio_code` |
| locked | output | 1 | Detected ratio confirmed by two matching frames |

## Verification
The hardest state to reach from the ports is counter saturation. Getting there needs the frame clock to stop for more than a thousand master clocks after the block has locked. The next edge must then be seen to measure as saturated instead of as a short period. The bench holds `frame_clk` low for 1100 cycles after a locked 512 run. It checks that the lock drops while the selection holds, and then that the first restarted frame pushes the selection to 768. The overlapping window edges (160, 224) and the exact outer bounds (96, 800) are driven as steady frame trains. A behavioural reference, which tracks raw edge times in integers and applies a four-cycle delay queue, is compared against the outputs on every clock.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int NUM_RATIOS = 6;

    typedef enum logic [2:0] {
        RATIO_128 = 3'd0,
        RATIO_192 = 3'd1,
        RATIO_256 = 3'd2,
        RATIO_384 = 3'd3,
        RATIO_512 = 3'd4,
        RATIO_768 = 3'd5
    } ratio_e;

    localparam ratio_e FALLBACK = RATIO_768;

    // Result of classifying one measured period
    typedef struct packed {
        ratio_e sel;
        logic   hit;
    } class_t;

    // Master clocks per frame for each ratio index
    function automatic int ratio_cycles(input int idx);
        case (idx)
            0:       return 128;
            1:       return 192;
            2:       return 256;
            3:       return 384;
            4:       return 512;
            default: return 768;
        endcase
    endfunction

    function automatic ratio_e cfg_to_ratio(input logic [2:0] c);
        return (c > 3'd5) ? FALLBACK : ratio_e'(c);
    endfunction

endpackage

// File: rtl/fsr_sync_edge.sv
module fsr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic din,
    output logic rise
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (clr) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/fsr_period_count.sv
module fsr_period_count #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             rise,
    output logic             meas_vld,
    output logic [CNT_W-1:0] meas_cnt
);
    localparam logic [CNT_W-1:0] SAT    = '1;
    localparam logic [CNT_W-1:0] SAT_M1 = SAT - 1'b1;

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic [CNT_W-1:0] period;

    // Cycles since the previous edge, pinned at the saturation value
    assign period = (cnt_q == SAT) ? SAT : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q    <= '0;
            armed_q  <= 1'b0;
            meas_vld <= 1'b0;
            meas_cnt <= '0;
        end else begin
            meas_vld <= 1'b0;
            if (rise) begin
                cnt_q   <= '0;
                armed_q <= 1'b1;
                if (armed_q) begin
                    meas_vld <= 1'b1;
                    meas_cnt <= period;
                end
            end else begin
                if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
                // a stopped frame clock reports once as saturated
                if (armed_q && cnt_q == SAT_M1) begin
                    meas_vld <= 1'b1;
                    meas_cnt <= SAT;
                end
            end
        end
    end
endmodule

// File: rtl/fsr_classify.sv
module fsr_classify
    import fsr_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int TOL   = 32
) (
    input  logic [CNT_W-1:0] count,
    output class_t           result
);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [NUM_RATIOS-1:0] hit;

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
        localparam int LO = ratio_cycles(i) - TOL;
        localparam int HI = ratio_cycles(i) + TOL;
        assign hit[i] = (count != SAT) && (int'(count) >= LO) && (int'(count) <= HI);
    end

    // lowest matching ratio wins where windows touch
    always_comb begin
        result.hit = |hit;
        result.sel = FALLBACK;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (hit[i]) result.sel = ratio_e'(3'(i));
        end
    end
endmodule

// File: rtl/fsr_lock_filter.sv
module fsr_lock_filter
    import fsr_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    input  logic   meas_vld,
    input  class_t cls,
    output ratio_e sel,
    output logic   locked
);
    logic   have_prev_q;
    class_t prev_q;
    logic   rep;

    assign rep = have_prev_q && (cls.sel == prev_q.sel);

    always_ff @(posedge clk) begin
        if (clr) begin
            have_prev_q <= 1'b0;
            prev_q      <= '{sel: FALLBACK, hit: 1'b0};
            sel         <= FALLBACK;
            locked      <= 1'b0;
        end else if (meas_vld) begin
            have_prev_q <= 1'b1;
            prev_q      <= cls;
            if (rep) sel <= cls.sel;
            locked <= rep && cls.hit && prev_q.hit;
        end
    end
endmodule

// File: rtl/fsratio_detect.sv
module fsratio_detect
    import fsr_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int TOL         = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  slave_mode,
    input  logic [2:0]            cfg_ratio,
    input  logic                  frame_clk,
    output logic [2:0]            ratio_code,
    output logic [NUM_RATIOS-1:0] ratio_onehot,
    output logic                  locked
);
    logic             det_clr;
    logic             fc_rise;
    logic             meas_vld;
    logic [CNT_W-1:0] meas_cnt;
    class_t           meas_cls;
    ratio_e           det_sel;
    logic             det_lock;
    ratio_e           code_d;
    logic             lock_d;

    // detector is held idle outside slave mode
    assign det_clr = rst | ~slave_mode;

    fsr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .clr  (det_clr),
        .din  (frame_clk),
        .rise (fc_rise)
    );

    fsr_period_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .clr      (det_clr),
        .rise     (fc_rise),
        .meas_vld (meas_vld),
        .meas_cnt (meas_cnt)
    );

    fsr_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
        .count  (meas_cnt),
        .result (meas_cls)
    );

    fsr_lock_filter u_lock (
        .clk      (clk),
        .clr      (det_clr),
        .meas_vld (meas_vld),
        .cls      (meas_cls),
        .sel      (det_sel),
        .locked   (det_lock)
    );

    always_comb begin
        code_d = slave_mode ? det_sel : cfg_to_ratio(cfg_ratio);
        lock_d = slave_mode ? det_lock : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_code <= 3'(FALLBACK);
            locked     <= 1'b0;
        end else begin
            ratio_code <= 3'(code_d);
            locked     <= lock_d;
        end
    end

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_onehot
        always_ff @(posedge clk) begin
            if (rst) ratio_onehot[i] <= (i == int'(FALLBACK));
            else     ratio_onehot[i] <= (int'(code_d) == i);
        end
    end
endmodule

// File: rtl/fsratio_detect_chk.sv
module fsratio_detect_chk (
    input logic       clk,
    input logic       rst,
    input logic       slave_mode,
    input logic [2:0] ratio_code,
    input logic [5:0] ratio_onehot,
    input logic       locked,
    input logic       meas_vld,
    input logic [2:0] det_sel
);
    // R1: reset drives the fallback ratio and clears lock
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (ratio_code == 3'd5 && ratio_onehot == 6'b100000 && !locked));

    // R2: only codes 0..5 appear
    p_code_range_r2: assert property (@(posedge clk) disable iff (rst)
        ratio_code <= 3'd5);

    // R2: exactly one selection line is active
    p_onehot_single_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(ratio_onehot) == 1);

    // R9: master mode always reports a lock
    p_master_locked_r9: assert property (@(posedge clk) disable iff (rst)
        !slave_mode |=> locked);

    // R7: the detector selection moves only right after a measurement
    p_sel_needs_meas_r7: assert property (@(posedge clk) disable iff (rst)
        (slave_mode && $past(slave_mode) && !$stable(det_sel)) |-> $past(meas_vld));
endmodule

bind fsratio_detect fsratio_detect_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .slave_mode   (slave_mode),
    .ratio_code   (ratio_code),
    .ratio_onehot (ratio_onehot),
    .locked       (locked),
    .meas_vld     (meas_vld),
    .det_sel      (det_sel)
);

// File: tb/fsratio_detect_tb_top.sv
`timescale 1ns/1ps
module fsratio_detect_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slave_mode = 1'b1;
    logic [2:0] cfg_ratio = 3'd0;
    logic       frame_clk = 1'b0;
    logic [2:0] ratio_code;
    logic [5:0] ratio_onehot;
    logic       locked;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;   // 200 MHz

    fsratio_detect dut_i (
        .clk          (clk),
        .rst          (rst),
        .slave_mode   (slave_mode),
        .cfg_ratio    (cfg_ratio),
        .frame_clk    (frame_clk),
        .ratio_code   (ratio_code),
        .ratio_onehot (ratio_onehot),
        .locked       (locked)
    );

    // ---------------- behavioural reference ----------------
    typedef struct { int due; int code; bit lock; } ev_t;
    ev_t pend[$];
    int  m_cyc = 0;
    int  m_last = 0;
    bit  m_armed = 0;
    bit  m_prevfc = 0;
    bit  h_have = 0;
    int  h_prev = 5;
    bit  h_prevhit = 0;
    int  h_sel = 5;
    bit  h_lock = 0;
    int  exp_code = 5;
    bit  exp_lock = 0;
    int  ratios[6] = '{128, 192, 256, 384, 512, 768};

    task automatic model_clear();
        m_armed = 0; m_prevfc = 0;
        h_have = 0; h_prev = 5; h_prevhit = 0; h_sel = 5; h_lock = 0;
        pend.delete();
    endtask

    task automatic feed(input int p);
        int  cls;
        bit  hit;
        bit  rep;
        cls = 5; hit = 0;
        if (p < 1023) begin
            for (int i = 5; i >= 0; i--) begin
                if (p >= ratios[i] - 32 && p <= ratios[i] + 32) begin
                    cls = i; hit = 1;
                end
            end
        end
        rep = h_have && (cls == h_prev);
        if (rep) h_sel = cls;
        h_lock = rep && hit && h_prevhit;
        h_have = 1; h_prev = cls; h_prevhit = hit;
        pend.push_back('{m_cyc + 4, h_sel, h_lock});
    endtask

    always @(posedge clk) begin
        m_cyc++;
        if (rst) begin
            model_clear();
            exp_code = 5; exp_lock = 0;
        end else if (!slave_mode) begin
            model_clear();
            exp_code = (cfg_ratio > 3'd5) ? 5 : int'(cfg_ratio);
            exp_lock = 1;
        end else begin
            while (pend.size() > 0 && pend[0].due == m_cyc) begin
                exp_code = pend[0].code;
                exp_lock = pend[0].lock;
                void'(pend.pop_front());
            end
            if (frame_clk && !m_prevfc) begin
                if (m_armed) feed((m_cyc - m_last > 1023) ? 1023 : m_cyc - m_last);
                m_armed = 1;
                m_last  = m_cyc;
            end else if (m_armed && (m_cyc - m_last == 1023)) begin
                feed(1023);
            end
            m_prevfc = frame_clk;
        end
    end

    // per-clock comparison (R10 timing plus the active phase's requirement)
    always @(negedge clk) begin
        if (m_cyc > 0 && !done) begin
            checks++;
            if (int'(ratio_code) != exp_code || locked != exp_lock ||
                ratio_onehot != 6'(1 << exp_code)) begin
                errors++;
                $display("FAIL R10/%s cycle %0d actual code=%0d lock=%0b oh=%b expected code=%0d lock=%0b",
                         cur_req, m_cyc, ratio_code, locked, ratio_onehot, exp_code, exp_lock);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string req, input string what, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic frames(input int p, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) frame_clk = 1'b1;
            repeat (p / 2 - 1) @(negedge clk);
            @(negedge clk) frame_clk = 1'b0;
            repeat (p - p / 2 - 1) @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_sel(input string req, input int code, input int lk);
        chk(req, "ratio_code", int'(ratio_code), code);
        chk(req, "locked", int'(locked), lk);
        chk(req, "ratio_onehot", int'(ratio_onehot), 1 << code);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (5) @(negedge clk);
        cur_req = "R1";
        expect_sel("R1", 5, 0);
        rst = 1'b0;

        // R2: every supported ratio, exact period
        cur_req = "R2";
        for (int i = 0; i < 6; i++) begin
            frames(ratios[i], 4);
            settle();
            expect_sel("R2", i, 1);
        end

        // R4: jitter inside the 256 window
        cur_req = "R4";
        frames(256, 3);
        for (int k = 0; k < 3; k++) begin
            frames(250, 1);
            frames(262, 1);
        end
        settle();
        expect_sel("R4", 2, 1);

        // R3: shared window values and outer bounds
        cur_req = "R3";
        frames(160, 4); settle(); expect_sel("R3", 0, 1);
        frames(224, 4); settle(); expect_sel("R3", 1, 1);
        frames(96, 4);  settle(); expect_sel("R3", 0, 1);
        frames(800, 4); settle(); expect_sel("R3", 5, 1);

        // R6: periods outside every window
        cur_req = "R6";
        frames(300, 4); settle(); expect_sel("R6", 5, 0);
        frames(384, 4); settle(); expect_sel("R6", 3, 1);
        frames(650, 4); settle(); expect_sel("R6", 5, 0);
        frames(801, 3); settle(); expect_sel("R6", 5, 0);
        frames(64, 4);  settle(); expect_sel("R6", 5, 0);

        // R7 / R5: one deviating frame inside a steady 512 run
        cur_req = "R7";
        frames(512, 4); settle(); expect_sel("R7", 4, 1);
        frames(256, 1);
        frames(512, 1);
        expect_sel("R7", 4, 0);   // R5: lock dropped, selection held
        frames(512, 3); settle(); expect_sel("R5", 4, 1);

        // R8: stopped frame clock saturates the counter
        cur_req = "R8";
        repeat (1100) @(negedge clk);
        expect_sel("R8", 4, 0);
        frames(512, 1);
        expect_sel("R8", 5, 0);
        frames(512, 4); settle(); expect_sel("R8", 4, 1);

        // R9: master mode follows configuration, frame clock ignored
        cur_req = "R9";
        @(negedge clk) begin rst = 1'b1; slave_mode = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 8; c++) begin
            cfg_ratio = 3'(c);
            frames(128, 1);
            expect_sel("R9", (c > 5) ? 5 : c, 1);
        end
        cfg_ratio = 3'd2;
        frames(512, 3);
        expect_sel("R9", 2, 1);

        // back to slave through reset
        cur_req = "R1";
        @(negedge clk) begin rst = 1'b1; slave_mode = 1'b1; end
        repeat (3) @(negedge clk);
        expect_sel("R1", 5, 0);
        rst = 1'b0;
        cur_req = "R2";
        frames(192, 4); settle(); expect_sel("R2", 1, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule